// File: doc/BRIEF.md
# Stepped DES Round Engine

This block performs the Data Encryption Standard one Feistel round at a time. The host writes a 64-bit data block and a 64-bit key into two eight-byte banks, byte index 0 holding the least significant byte. It then pulses `step` sixteen times. Each pulse runs one full round in a single clock cycle. After the sixteenth pulse the data bank holds the ciphertext or the plaintext, and `done` is high.

The initial permutation is folded into the first step. The final permutation and the swap of the halves are folded into the last step. The key passes through permuted choice 1 on the first step, and a 56-bit C/D register then carries the key schedule from round to round. For decryption the schedule rotates right instead of left, so the round keys come out in reverse order. The key banks keep the parity bits where they were written, and the schedule drops them without checking them.

Top module: `des_round_stepper`

## Requirements
- R1: After reset the data bank reads zero, `done` is low and the round counter is zero.
- R2: A write with `wr_key` low places `wr_byte` into bits [8*i+7:8*i] of `data_o`, where i is `wr_idx`. Index 0 is the least significant byte.
- R3: With `decrypt` low on the first step, sixteen steps leave the DES encryption of the data bank under the key bank on `data_o`. The key value is {key byte 7, …, key byte 0}, and its most significant bit is DES key bit 1.
- R4: With `decrypt` high on the first step, sixteen steps leave the DES decryption of the data bank on `data_o`.
- R5: The least significant bit of every key byte is a parity bit and has no effect on the result.
- R6: `done` stays low through the first fifteen steps and goes high in the cycle after the sixteenth step.
- R7: While `done` is high, `step` pulses leave `data_o` and `done` unchanged.
- R8: A data-byte write clears `done` and the round counter, so that the next step starts a new block. This holds even in the middle of a block.
- R9: `decrypt` is sampled only on the first step. Changing it during steps two to sixteen has no effect on the result.
- R10: A write and a step in the same cycle perform only the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_key | input | 1 | Selects the key bank (1) or the data bank (0) |
| wr_idx | input | 3 | Byte index within the selected bank |
| wr_byte | input | 8 | Byte to write |
| step | input | 1 | Runs one round when `done` is low |
| decrypt | input | 1 | Direction, sampled on the first step |
| data_o | output | 64 | Data bank contents |
| done | output | 1 | High once the sixteenth round has completed |

## Verification
The assertions assume that `step` is a clean single-cycle pulse sampled at the clock edge. They also assume that the key bank is not rewritten between the first and the sixteenth step, because the schedule takes its snapshot of the key on the first step. The bench loads all sixteen bytes while `step` is low and changes the key only between blocks. It changes `decrypt` in the middle of a block only in the scenario that tests R9. It issues one step together with a write only in the scenario that tests R10.

// File: rtl/des_round_stepper.sv
module des_round_stepper (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_key,
  input  logic [2:0]  wr_idx,
  input  logic [7:0]  wr_byte,
  input  logic        step,
  input  logic        decrypt,
  output logic [63:0] data_o,
  output logic        done
);

  localparam int IP_T [64] = '{58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
                               62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
                               57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
                               61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};
  localparam int FP_T [64] = '{40,8,48,16,56,24,64,32, 39,7,47,15,55,23,63,31,
                               38,6,46,14,54,22,62,30, 37,5,45,13,53,21,61,29,
                               36,4,44,12,52,20,60,28, 35,3,43,11,51,19,59,27,
                               34,2,42,10,50,18,58,26, 33,1,41,9,49,17,57,25};
  localparam int E_T [48] = '{32,1,2,3,4,5, 4,5,6,7,8,9, 8,9,10,11,12,13, 12,13,14,15,16,17,
                              16,17,18,19,20,21, 20,21,22,23,24,25, 24,25,26,27,28,29, 28,29,30,31,32,1};
  localparam int P_T [32] = '{16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
                              2,8,24,14,32,27,3,9, 19,13,30,6,22,11,4,25};
  localparam int PC1_T [56] = '{57,49,41,33,25,17,9, 1,58,50,42,34,26,18,
                                10,2,59,51,43,35,27, 19,11,3,60,52,44,36,
                                63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
                                14,6,61,53,45,37,29, 21,13,5,28,20,12,4};
  localparam int PC2_T [48] = '{14,17,11,24,1,5, 3,28,15,6,21,10, 23,19,12,4,26,8, 16,7,27,20,13,2,
                                41,52,31,37,47,55, 30,40,51,45,33,48, 44,49,39,56,34,53, 46,42,50,36,29,32};

  localparam int S1 [64] = '{14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7, 0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
                             4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0, 15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
  localparam int S2 [64] = '{15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10, 3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
                             0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15, 13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
  localparam int S3 [64] = '{10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8, 13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
                             13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7, 1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
  localparam int S4 [64] = '{7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15, 13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
                             10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4, 3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
  localparam int S5 [64] = '{2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9, 14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
                             4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14, 11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
  localparam int S6 [64] = '{12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11, 10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
                             9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6, 4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
  localparam int S7 [64] = '{4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1, 13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
                             1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2, 6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
  localparam int S8 [64] = '{13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7, 1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
                             7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8, 2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

  function automatic logic [63:0] perm64(input logic [63:0] x, input logic final_p);
    for (int i = 0; i < 64; i++)
      perm64[6'(63-i)] = x[6'(64 - (final_p ? FP_T[i] : IP_T[i]))];
  endfunction

  function automatic logic [55:0] pc1_f(input logic [63:0] x);
    for (int i = 0; i < 56; i++) pc1_f[6'(55-i)] = x[6'(64-PC1_T[i])];
  endfunction

  function automatic logic [47:0] pc2_f(input logic [55:0] x);
    for (int i = 0; i < 48; i++) pc2_f[6'(47-i)] = x[6'(56-PC2_T[i])];
  endfunction

  function automatic logic [47:0] e_f(input logic [31:0] x);
    for (int i = 0; i < 48; i++) e_f[6'(47-i)] = x[5'(32-E_T[i])];
  endfunction

  function automatic logic [31:0] p_f(input logic [31:0] x);
    for (int i = 0; i < 32; i++) p_f[5'(31-i)] = x[5'(32-P_T[i])];
  endfunction

  function automatic logic [3:0] sb(input int n, input logic [5:0] b);
    logic [5:0] a;
    a = {b[5], b[0], b[4:1]};
    case (n)
      0: sb = 4'(S1[a]);
      1: sb = 4'(S2[a]);
      2: sb = 4'(S3[a]);
      3: sb = 4'(S4[a]);
      4: sb = 4'(S5[a]);
      5: sb = 4'(S6[a]);
      6: sb = 4'(S7[a]);
      default: sb = 4'(S8[a]);
    endcase
  endfunction

  function automatic logic [31:0] sbox_all(input logic [47:0] x);
    for (int j = 0; j < 8; j++) sbox_all[31-4*j -: 4] = sb(j, x[47-6*j -: 6]);
  endfunction

  function automatic logic [27:0] rot(input logic [27:0] x, input logic right, input logic [1:0] amt);
    case ({right, amt})
      3'b001:  rot = {x[26:0], x[27]};
      3'b010:  rot = {x[25:0], x[27:26]};
      3'b101:  rot = {x[0], x[27:1]};
      3'b110:  rot = {x[1:0], x[27:2]};
      default: rot = x;
    endcase
  endfunction

  logic [63:0] data_q, key_q, blk, step_res;
  logic [55:0] cd_q, cd_src, cd_nxt;
  logic [31:0] fout, r_new;
  logic [3:0]  rnd_q;
  logic        dec_q, done_q, first, dir, single;
  logic [1:0]  amt;

  assign first  = (rnd_q == 4'd0);
  assign dir    = first ? decrypt : dec_q;
  assign blk    = first ? perm64(data_q, 1'b0) : data_q;
  assign cd_src = first ? pc1_f(key_q) : cd_q;
  assign single = dir ? (rnd_q == 4'd1 || rnd_q == 4'd8 || rnd_q == 4'd15)
                      : (rnd_q == 4'd0 || rnd_q == 4'd1 || rnd_q == 4'd8 || rnd_q == 4'd15);
  assign amt    = (dir && first) ? 2'd0 : (single ? 2'd1 : 2'd2);
  assign cd_nxt = {rot(cd_src[55:28], dir, amt), rot(cd_src[27:0], dir, amt)};
  assign fout   = p_f(sbox_all(e_f(blk[31:0]) ^ pc2_f(cd_nxt)));
  assign r_new  = blk[63:32] ^ fout;
  assign step_res = (rnd_q == 4'd15) ? perm64({r_new, blk[31:0]}, 1'b1) : {blk[31:0], r_new};

  assign data_o = data_q;
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      key_q  <= '0;
      cd_q   <= '0;
      rnd_q  <= '0;
      dec_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_key) key_q[{wr_idx, 3'b000} +: 8] <= wr_byte;
      else begin
        data_q[{wr_idx, 3'b000} +: 8] <= wr_byte;
        rnd_q  <= '0;
        done_q <= 1'b0;
      end
    end else if (step && !done_q) begin
      data_q <= step_res;
      cd_q   <= cd_nxt;
      rnd_q  <= rnd_q + 4'd1;
      if (first) dec_q <= decrypt;
      if (rnd_q == 4'd15) done_q <= 1'b1;
    end
  end

  a_r6_counter_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !done_q && !wr_en) |=> (rnd_q == 4'($past(rnd_q) + 4'd1)));
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !done_q && !wr_en && rnd_q == 4'd15) |=> done_q);
  a_r7_ignored_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wr_en) |=> ($stable(data_q) && done_q));
  a_r8_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_key) |=> (rnd_q == 4'd0 && !done_q));
  a_r9_direction_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_q != 4'd0) |=> $stable(dec_q));
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_key) |=> ($stable(data_q) && $stable(rnd_q)));

endmodule

// File: tb/des_round_stepper_tb.sv
module des_round_stepper_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_key = 1'b0, step = 1'b0, decrypt = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_byte = '0;
  logic [63:0] data_o;
  logic done;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  des_round_stepper u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key),
    .wr_idx(wr_idx), .wr_byte(wr_byte), .step(step), .decrypt(decrypt),
    .data_o(data_o), .done(done));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic key_sel, input logic [2:0] idx, input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_key = key_sel; wr_idx = idx; wr_byte = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load(input logic [63:0] d, input logic [63:0] k);
    for (int i = 0; i < 8; i++) wr(1'b1, 3'(i), k[8*i +: 8]);
    for (int i = 0; i < 8; i++) wr(1'b0, 3'(i), d[8*i +: 8]);
  endtask

  task automatic steps(input int n, input logic dec);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); step = 1'b1; decrypt = dec;
      @(negedge clk); step = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R1 data", data_o, 64'h0);
    chk("R1 done", {63'h0, done}, 64'h0);
  endtask

  task automatic t_bytes;
    load(64'h8877665544332211, 64'h0);
    chk("R2 byte order", data_o, 64'h8877665544332211);
  endtask

  task automatic t_encrypt;
    load(64'h0123456789ABCDEF, 64'h133457799BBCDFF1);
    steps(16, 1'b0);
    chk("R3 vector a", data_o, 64'h85E813540F0AB405);
    load(64'h8787878787878787, 64'h0E329232EA6D0D73);
    steps(16, 1'b0);
    chk("R3 vector b", data_o, 64'h0000000000000000);
    load(64'h0, 64'h0101010101010101);
    steps(16, 1'b0);
    chk("R3 vector c", data_o, 64'h8CA64DE9C1B123A7);
  endtask

  task automatic t_decrypt;
    load(64'h85E813540F0AB405, 64'h133457799BBCDFF1);
    steps(16, 1'b1);
    chk("R4 decrypt a", data_o, 64'h0123456789ABCDEF);
    load(64'h0000000000000000, 64'h0E329232EA6D0D73);
    steps(16, 1'b1);
    chk("R4 decrypt b", data_o, 64'h8787878787878787);
  endtask

  task automatic t_parity;
    load(64'h0, 64'h0);
    steps(16, 1'b0);
    chk("R5 parity cleared", data_o, 64'h8CA64DE9C1B123A7);
    load(64'h0123456789ABCDEF, 64'h123556789ABDDEF0);
    steps(16, 1'b0);
    chk("R5 parity flipped", data_o, 64'h85E813540F0AB405);
  endtask

  task automatic t_done;
    load(64'h0123456789ABCDEF, 64'h133457799BBCDFF1);
    steps(15, 1'b0);
    chk("R6 done low after 15", {63'h0, done}, 64'h0);
    steps(1, 1'b0);
    chk("R6 done high after 16", {63'h0, done}, 64'h1);
    steps(3, 1'b0);
    chk("R7 data held", data_o, 64'h85E813540F0AB405);
    chk("R7 done held", {63'h0, done}, 64'h1);
  endtask

  task automatic t_reload;
    load(64'h0123456789ABCDEF, 64'h133457799BBCDFF1);
    steps(7, 1'b0);
    for (int i = 0; i < 8; i++) wr(1'b0, 3'(i), 8'(64'h0123456789ABCDEF >> (8*i)));
    chk("R8 data reloaded", data_o, 64'h0123456789ABCDEF);
    chk("R8 done cleared", {63'h0, done}, 64'h0);
    steps(16, 1'b0);
    chk("R8 restart result", data_o, 64'h85E813540F0AB405);
  endtask

  task automatic t_direction;
    load(64'h0123456789ABCDEF, 64'h133457799BBCDFF1);
    steps(1, 1'b0);
    steps(15, 1'b1);
    chk("R9 encrypt held", data_o, 64'h85E813540F0AB405);
    load(64'h85E813540F0AB405, 64'h133457799BBCDFF1);
    steps(1, 1'b1);
    steps(15, 1'b0);
    chk("R9 decrypt held", data_o, 64'h0123456789ABCDEF);
  endtask

  task automatic t_priority;
    load(64'h0123456789ABCDEF, 64'h133457799BBCDFF1);
    @(negedge clk); step = 1'b1; wr_en = 1'b1; wr_key = 1'b1; wr_idx = 3'd0; wr_byte = 8'hF1;
    @(negedge clk); step = 1'b0; wr_en = 1'b0;
    chk("R10 no round on write", data_o, 64'h0123456789ABCDEF);
    steps(16, 1'b0);
    chk("R10 full block after", data_o, 64'h85E813540F0AB405);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_encrypt();
    t_decrypt();
    t_parity();
    t_done();
    t_reload();
    t_direction();
    t_priority();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule